// File: doc/BRIEF.md
# Raster Timing Generator in Eight-Pixel Units

This block produces horizontal sync, vertical sync and a data-enable strobe for a parallel RGB panel. Along a line, time is counted in units of eight pixel clocks: the line length, the visible width, the sync start and the sync length are all given in such units. Down the frame, time is counted in whole lines. Each sync output has its own polarity select.

The channel is switched on and off through a two-bit power status that climbs in steps on a start request and falls in steps on a stop request. One step takes a fixed number of frames. The counters run whenever the channel is not fully off. The panel sees sync pulses and data-enable only while the status is fully on.

Timing values go into a pending copy when `cfg_load` is pulsed. The pending copy moves to the active copy at the next frame boundary. While the channel is off it moves one clock later. Power states: OFF (status 0), RISE (status 1, stepping up), ON (status 3), FALL (status 1, stepping down). Transitions: OFF→RISE on `run` high; RISE→ON after STEP_FRAMES frame ends; ON→FALL on `run` low; FALL→OFF after STEP_FRAMES frame ends; RISE→FALL on `run` low; FALL→RISE on `run` high. Both reversals restart the frame count.

Top module: `panel_timing_gen`

## Requirements
- R1: A horizontal unit lasts 8 clocks. A line lasts H_total units, where H_total is `h_count_word[15:0]`. The unit counter wraps to 0 after unit H_total-1. A value of 0 behaves as 1.
- R2: A frame lasts V_total lines, where V_total is `v_count_word[15:0]`. The line counter advances when a line ends and wraps after line V_total-1. A value of 0 behaves as 1.
- R3: Horizontal sync is asserted while unit u satisfies HSP <= u < HSP+HSW. HSP is `h_sync_word[15:0]` and HSW is `h_sync_word[31:16]`.
- R4: Vertical sync is asserted while line l satisfies VSP <= l < VSP+VSW. VSP is `v_sync_word[15:0]` and VSW is `v_sync_word[31:16]`.
- R5: `pol_field[27]` set makes horizontal sync active-low. `pol_field[28]` set makes vertical sync active-low. Clear means active-high.
- R6: `de` is high when the status is 3, the unit is below `h_count_word[31:16]` and the line is below `v_count_word[31:16]`.
- R7: After `run` rises, the status goes 0→1 and then 1→3 after STEP_FRAMES further frame ends. It never jumps from 0 straight to 3.
- R8: After `run` falls while the status is 3, the status goes 3→1 and then 1→0 after STEP_FRAMES frame ends. It never jumps from 3 straight to 0.
- R9: While the status is not 3, `de` is 0 and each sync output sits at its inactive level.
- R10: A `cfg_load` while the counters run takes effect at the start of the next frame. While the status is 0 (OFF), it takes effect two clocks after the pulse.
- R11: During reset the status is 0, `de` is 0 and both syncs are low (active values cleared).
- R12: Toggling `run` while the status is 1 reverses direction and restarts the frame count. The status stays at 1 until the new direction completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Channel start (1) / stop (0) request |
| cfg_load | input | 1 | Captures the timing words into the pending copy |
| h_count_word | input | 32 | [15:0] line length in units, [31:16] visible units |
| h_sync_word | input | 32 | [15:0] sync start unit, [31:16] sync length in units |
| v_count_word | input | 32 | [15:0] frame length in lines, [31:16] visible lines |
| v_sync_word | input | 32 | [15:0] sync start line, [31:16] sync length in lines |
| pol_field | input | 2 | Bits 28:27 of the mode word: vertical / horizontal active-low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pwr_status | output | 2 | Power status: 0 off, 1 stepping, 3 on |

## Verification
The bench aims at sync windows that run past the end of a line or frame and so must be cut off by the wrap. A wrong comparison there would leave sync stuck across the boundary. It also covers a one-unit line and a visible area equal to the full total. An off-by-one counter would show these as a missing or extra unit of `de`. Timing is rewritten mid-frame to catch a design that switches values at once, which would tear the current frame. `run` is flipped during both ramps to catch a status that skips straight between 0 and 3, or one that keeps its old frame count.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int FIELD_W    = 16;
    localparam int WORD_W     = 2 * FIELD_W;
    localparam int VS_LOW_BIT = 28;
    localparam int HS_LOW_BIT = 27;

    typedef logic [FIELD_W-1:0] field_t;

    typedef enum logic [1:0] {
        PW_OFF  = 2'd0,
        PW_RISE = 2'd1,
        PW_ON   = 2'd2,
        PW_FALL = 2'd3
    } pwr_state_e;

    typedef struct packed {
        field_t h_total;
        field_t h_disp;
        field_t h_sp;
        field_t h_sw;
        field_t v_total;
        field_t v_disp;
        field_t v_sp;
        field_t v_sw;
        logic   hs_low;
        logic   vs_low;
    } tcfg_t;

    function automatic tcfg_t unpack_cfg(input logic [WORD_W-1:0] hc,
                                         input logic [WORD_W-1:0] hs,
                                         input logic [WORD_W-1:0] vc,
                                         input logic [WORD_W-1:0] vs,
                                         input logic [VS_LOW_BIT:HS_LOW_BIT] pol);
        tcfg_t c;
        c.h_total = hc[FIELD_W-1:0];
        c.h_disp  = hc[WORD_W-1:FIELD_W];
        c.h_sp    = hs[FIELD_W-1:0];
        c.h_sw    = hs[WORD_W-1:FIELD_W];
        c.v_total = vc[FIELD_W-1:0];
        c.v_disp  = vc[WORD_W-1:FIELD_W];
        c.v_sp    = vs[FIELD_W-1:0];
        c.v_sw    = vs[WORD_W-1:FIELD_W];
        c.hs_low  = pol[HS_LOW_BIT];
        c.vs_low  = pol[VS_LOW_BIT];
        return c;
    endfunction
endpackage

// File: rtl/ptg_power_seq.sv
module ptg_power_seq import ptg_pkg::*; #(
    parameter int STEP_FRAMES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       frame_end,
    output pwr_state_e state,
    output logic [1:0] pwr_status
);
    localparam int FC_W = (STEP_FRAMES > 1) ? $clog2(STEP_FRAMES) : 1;
    localparam logic [FC_W-1:0] FC_LAST = FC_W'(STEP_FRAMES - 1);

    pwr_state_e      nxt;
    logic [FC_W-1:0] fcnt, fcnt_nxt;

    always_comb begin
        nxt      = state;
        fcnt_nxt = fcnt;
        unique case (state)
            PW_OFF: begin
                if (run) begin
                    nxt      = PW_RISE;
                    fcnt_nxt = '0;
                end
            end
            PW_RISE: begin
                if (!run) begin
                    nxt      = PW_FALL;
                    fcnt_nxt = '0;
                end else if (frame_end) begin
                    if (fcnt == FC_LAST) begin
                        nxt      = PW_ON;
                        fcnt_nxt = '0;
                    end else begin
                        fcnt_nxt = fcnt + FC_W'(1);
                    end
                end
            end
            PW_ON: begin
                if (!run) begin
                    nxt      = PW_FALL;
                    fcnt_nxt = '0;
                end
            end
            PW_FALL: begin
                if (run) begin
                    nxt      = PW_RISE;
                    fcnt_nxt = '0;
                end else if (frame_end) begin
                    if (fcnt == FC_LAST) begin
                        nxt      = PW_OFF;
                        fcnt_nxt = '0;
                    end else begin
                        fcnt_nxt = fcnt + FC_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PW_OFF;
            fcnt  <= '0;
        end else begin
            state <= nxt;
            fcnt  <= fcnt_nxt;
        end
    end

    always_comb begin
        unique case (state)
            PW_OFF:           pwr_status = 2'b00;
            PW_RISE, PW_FALL: pwr_status = 2'b01;
            PW_ON:            pwr_status = 2'b11;
        endcase
    end

    // R7
    off_not_to_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == 2'b00) |=> (pwr_status != 2'b11));
    // R8
    on_not_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == 2'b11) |=> (pwr_status != 2'b00));
    // R7
    step_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_status == 2'b01 && !frame_end) |=> (pwr_status == 2'b01));
endmodule

// File: rtl/ptg_raster_cnt.sv
module ptg_raster_cnt import ptg_pkg::*; #(
    parameter int UNIT_PIX = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  field_t h_total,
    input  field_t v_total,
    output field_t hu,
    output field_t ln,
    output logic   frame_end
);
    localparam int SUB_W = (UNIT_PIX > 1) ? $clog2(UNIT_PIX) : 1;
    localparam int CW    = FIELD_W + 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(UNIT_PIX - 1);

    logic [SUB_W-1:0] sub;
    logic             hu_last, ln_last, sub_last;

    assign sub_last  = (sub == SUB_LAST);
    assign hu_last   = (CW'(hu) + CW'(1)) >= CW'(h_total);
    assign ln_last   = (CW'(ln) + CW'(1)) >= CW'(v_total);
    assign frame_end = enable && sub_last && hu_last && ln_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub <= '0;
            hu  <= '0;
            ln  <= '0;
        end else if (!enable) begin
            sub <= '0;
            hu  <= '0;
            ln  <= '0;
        end else if (sub_last) begin
            sub <= '0;
            if (hu_last) begin
                hu <= '0;
                ln <= ln_last ? '0 : ln + field_t'(1);
            end else begin
                hu <= hu + field_t'(1);
            end
        end else begin
            sub <= sub + SUB_W'(1);
        end
    end

    // R1
    unit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !sub_last) |=> (hu == $past(hu) && ln == $past(ln)));
    // R2
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |=> (hu == '0 && ln == '0));
endmodule

// File: rtl/ptg_sync_decode.sv
module ptg_sync_decode import ptg_pkg::*; (
    input  field_t hu,
    input  field_t ln,
    input  logic   on,
    input  field_t h_disp,
    input  field_t h_sp,
    input  field_t h_sw,
    input  field_t v_disp,
    input  field_t v_sp,
    input  field_t v_sw,
    input  logic   hs_low,
    input  logic   vs_low,
    output logic   hsync,
    output logic   vsync,
    output logic   de
);
    localparam int CW = FIELD_W + 1;

    logic hs_act, vs_act;

    assign hs_act = (hu >= h_sp) && (CW'(hu) < CW'(h_sp) + CW'(h_sw));
    assign vs_act = (ln >= v_sp) && (CW'(ln) < CW'(v_sp) + CW'(v_sw));

    assign hsync = on ? (hs_act ^ hs_low) : hs_low;
    assign vsync = on ? (vs_act ^ vs_low) : vs_low;
    assign de    = on && (hu < h_disp) && (ln < v_disp);
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen import ptg_pkg::*; #(
    parameter int UNIT_PIX    = 8,
    parameter int STEP_FRAMES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run,
    input  logic                         cfg_load,
    input  logic [WORD_W-1:0]            h_count_word,
    input  logic [WORD_W-1:0]            h_sync_word,
    input  logic [WORD_W-1:0]            v_count_word,
    input  logic [WORD_W-1:0]            v_sync_word,
    input  logic [VS_LOW_BIT:HS_LOW_BIT] pol_field,
    output logic                         hsync,
    output logic                         vsync,
    output logic                         de,
    output logic [1:0]                   pwr_status
);
    tcfg_t      pend, act;
    pwr_state_e state;
    field_t     hu, ln;
    logic       frame_end, running, on;

    assign running = (state != PW_OFF);
    assign on      = (state == PW_ON);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend <= '0;
            act  <= '0;
        end else begin
            if (cfg_load)
                pend <= unpack_cfg(h_count_word, h_sync_word, v_count_word,
                                   v_sync_word, pol_field);
            if (!running || frame_end)
                act <= pend;
        end
    end

    ptg_power_seq #(.STEP_FRAMES(STEP_FRAMES)) u_pwr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .frame_end  (frame_end),
        .state      (state),
        .pwr_status (pwr_status)
    );

    ptg_raster_cnt #(.UNIT_PIX(UNIT_PIX)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (running),
        .h_total   (act.h_total),
        .v_total   (act.v_total),
        .hu        (hu),
        .ln        (ln),
        .frame_end (frame_end)
    );

    ptg_sync_decode u_dec (
        .hu     (hu),
        .ln     (ln),
        .on     (on),
        .h_disp (act.h_disp),
        .h_sp   (act.h_sp),
        .h_sw   (act.h_sw),
        .v_disp (act.v_disp),
        .v_sp   (act.v_sp),
        .v_sw   (act.v_sw),
        .hs_low (act.hs_low),
        .vs_low (act.vs_low),
        .hsync  (hsync),
        .vsync  (vsync),
        .de     (de)
    );

    // R6
    de_only_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (pwr_status == 2'b11));
    // R10
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !frame_end) |=> $stable(act));
endmodule

// File: tb/tb_panel_timing_gen.sv
`timescale 1ns/1ps
module tb_panel_timing_gen;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cfg_load = 1'b0;
    logic [31:0] h_count_word = '0, h_sync_word = '0, v_count_word = '0, v_sync_word = '0;
    logic [28:27] pol_field = '0;
    logic        hsync, vsync, de;
    logic [1:0]  pwr_status;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_en = 0, done = 0;
    string phase = "R7";
    int unsigned seed_val;

    // idx: 0 htot 1 hdisp 2 hsp 3 hsw 4 vtot 5 vdisp 6 vsp 7 vsw 8 hs_low 9 vs_low
    int in_v[10];
    int p[10];
    int a[10];
    int m_st = 0, m_f = 0, m_sub = 0, m_hu = 0, m_ln = 0;

    always #10 clk = ~clk;

    panel_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .run(run), .cfg_load(cfg_load),
        .h_count_word(h_count_word), .h_sync_word(h_sync_word),
        .v_count_word(v_count_word), .v_sync_word(v_sync_word),
        .pol_field(pol_field), .hsync(hsync), .vsync(vsync), .de(de),
        .pwr_status(pwr_status)
    );

    task automatic chk(input string tag, input string what, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    // reference model, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        int fe, hl, ll, was_off;
        if (!rst_n) begin
            m_st = 0; m_f = 0; m_sub = 0; m_hu = 0; m_ln = 0;
            for (int i = 0; i < 10; i++) begin a[i] = 0; p[i] = 0; end
        end else begin
            was_off = (m_st == 0);
            hl = (m_hu + 1 >= a[0]);
            ll = (m_ln + 1 >= a[4]);
            fe = (m_st != 0) && (m_sub == 7) && hl && ll;
            if (m_st == 0) begin
                m_sub = 0; m_hu = 0; m_ln = 0;
            end else if (m_sub == 7) begin
                m_sub = 0;
                if (hl) begin m_hu = 0; m_ln = ll ? 0 : m_ln + 1; end
                else m_hu = m_hu + 1;
            end else m_sub = m_sub + 1;
            case (m_st)
                0: if (run) begin m_st = 1; m_f = 0; end
                1: if (!run) begin m_st = 3; m_f = 0; end
                   else if (fe) begin
                       if (m_f == N - 1) begin m_st = 2; m_f = 0; end else m_f = m_f + 1;
                   end
                2: if (!run) begin m_st = 3; m_f = 0; end
                default: if (run) begin m_st = 1; m_f = 0; end
                   else if (fe) begin
                       if (m_f == N - 1) begin m_st = 0; m_f = 0; end else m_f = m_f + 1;
                   end
            endcase
            if (was_off || fe) for (int i = 0; i < 10; i++) a[i] = p[i];
            if (cfg_load) for (int i = 0; i < 10; i++) p[i] = in_v[i];
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        int on, hs_act, vs_act, e_hs, e_vs, e_de, e_st;
        if (rst_n && cmp_en && !done) begin
            on = (m_st == 2);
            hs_act = (m_hu >= a[2]) && (m_hu < a[2] + a[3]);
            vs_act = (m_ln >= a[6]) && (m_ln < a[6] + a[7]);
            e_hs = on ? (hs_act ^ a[8]) : a[8];
            e_vs = on ? (vs_act ^ a[9]) : a[9];
            e_de = on && (m_hu < a[1]) && (m_ln < a[5]);
            e_st = (m_st == 0) ? 0 : (m_st == 2) ? 3 : 1;
            chk($sformatf("R1,R3,R5 [%s]", phase), "hsync", int'(hsync), e_hs);
            chk($sformatf("R2,R4,R5 [%s]", phase), "vsync", int'(vsync), e_vs);
            chk($sformatf("R6,R9 [%s]", phase), "de", int'(de), e_de);
            chk(phase, "pwr_status", int'(pwr_status), e_st);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", cyc, 190000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic rand_cfg();
        in_v[0] = int'($urandom_range(8, 3));
        in_v[1] = int'($urandom_range(in_v[0], 1));
        in_v[2] = int'($urandom_range(in_v[0] - 1, 0));
        in_v[3] = int'($urandom_range(2, 1));
        in_v[4] = int'($urandom_range(10, 3));
        in_v[5] = int'($urandom_range(in_v[4], 1));
        in_v[6] = int'($urandom_range(in_v[4] - 1, 0));
        in_v[7] = int'($urandom_range(2, 1));
        in_v[8] = int'($urandom_range(1, 0));
        in_v[9] = int'($urandom_range(1, 0));
    endtask

    task automatic set_cfg(input int ht, input int hd, input int hp, input int hw,
                           input int vt, input int vd, input int vp, input int vw,
                           input int hl, input int vl);
        in_v[0] = ht; in_v[1] = hd; in_v[2] = hp; in_v[3] = hw;
        in_v[4] = vt; in_v[5] = vd; in_v[6] = vp; in_v[7] = vw;
        in_v[8] = hl; in_v[9] = vl;
    endtask

    task automatic load();
        h_count_word = {16'(in_v[1]), 16'(in_v[0])};
        h_sync_word  = {16'(in_v[3]), 16'(in_v[2])};
        v_count_word = {16'(in_v[5]), 16'(in_v[4])};
        v_sync_word  = {16'(in_v[7]), 16'(in_v[6])};
        pol_field    = {1'(in_v[9]), 1'(in_v[8])};
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_status(input int v);
        for (int k = 0; k < 20000; k++) begin
            if (int'(pwr_status) == v) break;
            @(negedge clk);
        end
    endtask

    initial begin
        seed_val = $urandom(32'd4099);
        repeat (3) @(negedge clk);
        chk("R11", "pwr_status in reset", int'(pwr_status), 0);
        chk("R11", "de in reset", int'(de), 0);
        chk("R11", "hsync in reset", int'(hsync), 0);
        chk("R11", "vsync in reset", int'(vsync), 0);
        rst_n = 1'b1;
        cmp_en = 1;
        @(negedge clk);

        for (int s = 0; s < 5; s++) begin
            if (s == 0)      set_cfg(5, 5, 4, 2, 4, 4, 3, 2, 1, 1); // sync wraps past end, full visible
            else if (s == 1) set_cfg(1, 1, 0, 1, 2, 1, 1, 1, 0, 0); // one-unit line
            else             rand_cfg();
            phase = "R7";
            load();
            run = 1'b1;
            wait_status(3);
            repeat (1200) @(negedge clk);
            phase = "R10";
            rand_cfg();
            repeat (37) @(negedge clk);
            load();
            repeat (1500) @(negedge clk);
            if (s == 2) begin
                phase = "R12";
                run = 1'b0;
                repeat (60) @(negedge clk);
                run = 1'b1;
                wait_status(3);
                repeat (200) @(negedge clk);
            end
            phase = "R8";
            run = 1'b0;
            wait_status(0);
            repeat (40) @(negedge clk);
        end

        phase = "R12";
        rand_cfg();
        load();
        run = 1'b1;
        repeat (300) @(negedge clk);
        run = 1'b0;
        repeat (300) @(negedge clk);
        run = 1'b1;
        wait_status(3);
        repeat (300) @(negedge clk);
        run = 1'b0;
        wait_status(0);
        repeat (10) @(negedge clk);

        phase = "R9";
        set_cfg(4, 2, 1, 1, 4, 2, 1, 1, 1, 1);
        load();
        repeat (3) @(negedge clk);
        chk("R5,R9", "idle hsync active-low", int'(hsync), 1);
        chk("R5,R9", "idle vsync active-low", int'(vsync), 1);
        chk("R9", "idle de", int'(de), 0);
        set_cfg(4, 2, 1, 1, 4, 2, 1, 1, 0, 0);
        load();
        repeat (3) @(negedge clk);
        chk("R5,R9", "idle hsync active-high", int'(hsync), 0);
        chk("R5,R9", "idle vsync active-high", int'(vsync), 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule